// File: doc/BRIEF.md
# Quadrature-Phase Commutation Pattern Decoder

This block recovers the three motor commutation signals and the once-per-turn index from an encoder. The encoder sends these signals on one multiplexed line, C, next to its quadrature pair A and B. Within each commutation sector, C follows a fixed Boolean function of A and B. The block reads that function directly and does not search a history of samples. It keeps one stored bit for each of the four quadrature phases. Each time a phase is entered, the level of C is written into that phase's bit. After all four phases have been visited, the four bits hold the truth table of the current sector's function.

Six functions can occur: NOT A, NOT B, A AND NOT B, B AND NOT A, NOR and XOR. A three-input match on the stored bits for the phases where A and B are not both high selects the sector. A parameter table then maps the sector to a six-step U/V/W code. C is never high in the phase where A and B are both high, except during the index mark. The block therefore flags the index whenever A, B and C are all high. The inputs are expected to be already synchronised and filtered, one sample per clock.

Top module: `commut_decoder`

## Requirements
- R1: The quadrature phase is the pair {A,B}, and the stored bit it selects has index 2*A + B (bit 0: A=0,B=0; bit 1: A=0,B=1; bit 2: A=1,B=0; bit 3: A=1,B=1).
- R2: A phase's stored bit takes the level of C in the first cycle the block sees that phase: on a change of {A,B}, or in the first cycle after reset. A change of C while {A,B} stays the same leaves every stored bit unchanged.
- R3: The sector is found by matching stored bits {bit2,bit1,bit0} exactly: 011 is NOT A, 101 is NOT B, 100 is A AND NOT B, 010 is B AND NOT A, 001 is NOR, 110 is XOR. Bit 3 takes no part in the match.
- R4: With the default table, the output {U,V,W} is 100 for NOT A, 110 for NOT B, 010 for A AND NOT B, 011 for B AND NOT A, 001 for NOR and 101 for XOR.
- R5: When the stored bits match no sector (000 or 111), {U,V,W} keeps its previous value.
- R6: After reset, U, V, W and the locked flag stay low until all four stored bits have been written at least once. The bit for A=1,B=1 counts as written whatever level C has. Once locked, the flag stays high until the next reset.
- R7: The index output is high exactly one cycle after a cycle in which A, B and C are all high, and is otherwise low.
- R8: Moving through the phases of one sector in reverse order, or turning back within a sector, leaves {U,V,W} unchanged.
- R9: All outputs are registered. A change on A, B or C shows at the outputs after the next rising clock edge, and not before.
- R10: A synchronous active-high reset drives U, V, W, the index output and the locked flag low, and clears all stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Quadrature channel A, synchronised |
| enc_b | input | 1 | Quadrature channel B, synchronised |
| enc_c | input | 1 | Multiplexed commutation/index channel, synchronised |
| com_u | output | 1 | Commutation phase U |
| com_v | output | 1 | Commutation phase V |
| com_w | output | 1 | Commutation phase W |
| idx_z | output | 1 | Index mark |
| locked | output | 1 | High once every phase bit has been written since reset |

## Verification
The assertions assume that A, B and C are clean synchronous samples. They assume that C within a sector is a steady function of {A,B}, so re-entering a phase in the same sector writes the same level. They also assume that C is high with A and B both high only at the index mark. The stimulus drives one input change per clock, away from the active edge, and walks each sector through single-step Gray moves of {A,B}. It deliberately breaks the second assumption only in the directed cases that exercise the write-on-entry rule and the hold on an unmatched code.

// File: rtl/commut_pkg.sv
package commut_pkg;

    localparam int PHASES  = 4;
    localparam int PH_W    = $clog2(PHASES);
    localparam int SECTORS = 6;
    localparam int KEY_W   = 3;
    localparam int UVW_W   = 3;

    typedef enum logic [2:0] {
        SEC_NOT_A = 3'd0,
        SEC_NOT_B = 3'd1,
        SEC_A_NB  = 3'd2,
        SEC_B_NA  = 3'd3,
        SEC_NOR   = 3'd4,
        SEC_XOR   = 3'd5
    } sector_e;

    typedef struct packed {
        logic u;
        logic v;
        logic w;
    } uvw_t;

    typedef struct packed {
        logic    hit;
        sector_e sec;
    } match_t;

    // Truth-table key of each sector over stored bits {ph10, ph01, ph00}.
    function automatic logic [KEY_W-1:0] sector_key(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 3'b011;
            1:       k = 3'b101;
            2:       k = 3'b100;
            3:       k = 3'b010;
            4:       k = 3'b001;
            default: k = 3'b110;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/commut_phase_mem.sv
module commut_phase_mem
    import commut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a,
    input  logic              b,
    input  logic              c,
    output logic [PHASES-1:0] mem_nx,
    output logic [PHASES-1:0] wr_nx
);

    logic [PH_W-1:0]   ph;
    logic [PH_W-1:0]   ph_q;
    logic              seen_q;
    logic [PHASES-1:0] mem_q;
    logic [PHASES-1:0] wr_q;
    logic              enter;

    assign ph    = {a, b};
    assign enter = !seen_q || (ph != ph_q);

    always_comb begin
        mem_nx = mem_q;
        wr_nx  = wr_q;
        if (enter) begin
            mem_nx[ph] = c;
            wr_nx[ph]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            seen_q <= 1'b0;
            mem_q  <= '0;
            wr_q   <= '0;
        end else begin
            ph_q   <= ph;
            seen_q <= 1'b1;
            mem_q  <= mem_nx;
            wr_q   <= wr_nx;
        end
    end

    // R2: entering a new phase stores the C level seen at entry
    p_entry_write_r2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ({a, b} != ph_q)) |=> (mem_q[ph_q] == $past(c)));

    // R2: staying in a phase leaves every stored bit alone
    p_stay_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && ({a, b} == ph_q)) |=> $stable(mem_q));

endmodule

// File: rtl/commut_pat_match.sv
module commut_pat_match
    import commut_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output match_t           m
);

    logic [SECTORS-1:0] det;

    for (genvar i = 0; i < SECTORS; i++) begin : g_det
        localparam logic [KEY_W-1:0] K = sector_key(i);
        // three-input AND of true/complemented stored bits
        assign det[i] = &(~(key ^ K));
    end

    always_comb begin
        m.hit = |det;
        m.sec = SEC_NOT_A;
        for (int i = 0; i < SECTORS; i++) begin
            if (det[i]) m.sec = sector_e'(i);
        end
    end

endmodule

// File: rtl/commut_uvw_out.sv
module commut_uvw_out
    import commut_pkg::*;
#(
    parameter logic [SECTORS*UVW_W-1:0] UVW_TABLE =
        {3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100}
)(
    input  logic   clk,
    input  logic   rst,
    input  match_t m,
    input  logic   full,
    output uvw_t   uvw_q,
    output logic   locked_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            uvw_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            locked_q <= full;
            if (!full)
                uvw_q <= '0;
            else if (m.hit)
                uvw_q <= uvw_t'(UVW_TABLE[int'(m.sec)*UVW_W +: UVW_W]);
        end
    end

    // R6: once locked, stays locked until reset
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);

    // R5: an unmatched code holds the commutation outputs
    p_miss_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !m.hit) |=> $stable(uvw_q));

endmodule

// File: rtl/commut_decoder.sv
module commut_decoder
    import commut_pkg::*;
#(
    parameter logic [SECTORS*UVW_W-1:0] UVW_TABLE =
        {3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100}
)(
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    input  logic enc_c,
    output logic com_u,
    output logic com_v,
    output logic com_w,
    output logic idx_z,
    output logic locked
);

    logic [PHASES-1:0] mem_nx;
    logic [PHASES-1:0] wr_nx;
    match_t            m;
    uvw_t              uvw;
    logic              z_q;

    commut_phase_mem u_mem (
        .clk    (clk),
        .rst    (rst),
        .a      (enc_a),
        .b      (enc_b),
        .c      (enc_c),
        .mem_nx (mem_nx),
        .wr_nx  (wr_nx)
    );

    commut_pat_match u_match (
        .key (mem_nx[KEY_W-1:0]),
        .m   (m)
    );

    commut_uvw_out #(.UVW_TABLE(UVW_TABLE)) u_out (
        .clk      (clk),
        .rst      (rst),
        .m        (m),
        .full     (&wr_nx),
        .uvw_q    (uvw),
        .locked_q (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) z_q <= 1'b0;
        else     z_q <= enc_a & enc_b & enc_c;
    end

    assign com_u = uvw.u;
    assign com_v = uvw.v;
    assign com_w = uvw.w;
    assign idx_z = z_q;

    // R7: index follows A&B&C by one cycle
    p_index_set_r7: assert property (@(posedge clk) disable iff (rst)
        (enc_a && enc_b && enc_c) |=> idx_z);

    p_index_clr_r7: assert property (@(posedge clk) disable iff (rst)
        !(enc_a && enc_b && enc_c) |=> !idx_z);

    // R6: unlocked means all commutation outputs low
    p_unlocked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !locked |-> ({com_u, com_v, com_w} == 3'b000));

endmodule

// File: tb/commut_decoder_test.sv
`timescale 1ns/1ps
module commut_decoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ea = 1'b0, eb = 1'b0, ec = 1'b0;
    logic cu, cv, cw, iz, lk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    commut_decoder uut (
        .clk(clk), .rst(rst),
        .enc_a(ea), .enc_b(eb), .enc_c(ec),
        .com_u(cu), .com_v(cv), .com_w(cw),
        .idx_z(iz), .locked(lk)
    );

    // {truth table indexed by 2*A+B, expected UVW}
    localparam logic [6:0] SECTOR_VEC [6] = '{
        {4'b0101, 3'b110},   // NOT B
        {4'b0100, 3'b010},   // A AND NOT B
        {4'b0010, 3'b011},   // B AND NOT A
        {4'b0001, 3'b001},   // NOR
        {4'b0110, 3'b101},   // XOR
        {4'b0011, 3'b100}    // NOT A
    };
    localparam logic [1:0] WALK [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b, input logic c);
        ea = a; eb = b; ec = c;
        @(negedge clk);
    endtask

    function automatic logic [3:0] uvw();
        return {1'b0, cu, cv, cw};
    endfunction

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 uvw in reset", uvw(), 4'b0000);
        check("R10 lock/index in reset", {2'b00, lk, iz}, 4'b0000);

        // R6 lock sequence with NOT A, R1 bit placement
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        check("R6 not locked after one phase", {lk, cu, cv, cw}, 4'b0000);
        step(1'b1, 1'b0, 1'b0);
        check("R6 not locked after two phases", {lk, cu, cv, cw}, 4'b0000);
        step(1'b1, 1'b1, 1'b0);
        check("R6 not locked after three phases", {lk, cu, cv, cw}, 4'b0000);
        step(1'b0, 1'b1, 1'b1);
        check("R6 locked after four phases", {3'b000, lk}, 4'b0001);
        check("R1 R3 R4 NOT A from bit placement", uvw(), 4'b0100);

        // table walk through every sector (R3, R4)
        for (int s = 0; s < 6; s++) begin
            for (int p = 0; p < 4; p++) begin
                step(WALK[p][1], WALK[p][0], SECTOR_VEC[s][3 + int'(WALK[p])]);
                check("R7 index low in sector walk", {3'b000, iz}, 4'b0000);
            end
            check($sformatf("R3 R4 sector %0d", s), uvw(), {1'b0, SECTOR_VEC[s][2:0]});
        end

        // R2: C changes while staying in phase 01 are ignored (NOT A held)
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check("R2 C change without phase change ignored", uvw(), 4'b0100);
        step(1'b0, 1'b0, 1'b1);
        check("R2 re-entry same level keeps NOT A", uvw(), 4'b0100);
        step(1'b0, 1'b1, 1'b0);
        check("R2 entry writes C (NOR)", uvw(), 4'b0001);

        // R5: code 000 matches nothing, hold NOR
        step(1'b0, 1'b0, 1'b0);
        check("R5 unmatched code holds", uvw(), 4'b0001);
        check("R6 lock stays high", {3'b000, lk}, 4'b0001);

        // XOR sector walk
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R3 R4 XOR after walk", uvw(), 4'b0101);

        // R8: reversal inside XOR
        step(1'b1, 1'b1, 1'b0);
        check("R8 reverse to 11", uvw(), 4'b0101);
        step(1'b1, 1'b0, 1'b1);
        check("R8 reverse to 10", uvw(), 4'b0101);
        step(1'b1, 1'b1, 1'b0);
        check("R8 forward again to 11", uvw(), 4'b0101);
        step(1'b0, 1'b1, 1'b1);
        check("R8 back to 01", uvw(), 4'b0101);

        // R7, R9: index mark
        ea = 1'b1; eb = 1'b1; ec = 1'b1;
        #1;
        check("R9 index not before clock edge", {3'b000, iz}, 4'b0000);
        @(negedge clk);
        check("R7 index high after A&B&C", {3'b000, iz}, 4'b0001);
        check("R3 bit 3 ignored by match", uvw(), 4'b0101);
        step(1'b1, 1'b1, 1'b0);
        check("R7 index drops with C", {3'b000, iz}, 4'b0000);

        // R10: reset in operation
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears outputs", {lk, cu, cv, cw}, 4'b0000);
        check("R10 reset clears index", {3'b000, iz}, 4'b0000);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule